// File: doc/BRIEF.md
# Sequential Horner Polynomial Evaluator

This block computes the value of a fixed polynomial at a signed input `x`. It uses Horner's nesting, so each clock cycle performs one multiply-add step. The coefficients are set by a parameter. The coefficient of x^k sits at position k, so higher powers sit at higher positions. Evaluation starts with the coefficient of the highest power and works down to the constant term.

An evaluation begins when a reload happens. A reload is either a synchronous active-low reset or a one-cycle `start` pulse. For a polynomial of degree d, `done` rises d clock edges after the reload edge. From that point `y` holds the result until the next reload. The caller keeps `x` steady from the reload until `done` is high. While `done` is low, the value on `y` is an intermediate partial sum.

Top module: `horner_eval`

## Requirements
- R1: With the default coefficients (x^3 term 3, x^2 term -2, x term -4, constant 5, coefficient of x^k at position k), the value on `y` when `done` is high equals 3x^3 - 2x^2 - 4x + 5 for the `x` applied.
- R2: A rising edge with `rst_n` low clears `done` and places the highest-power coefficient (3 by default) on `y`.
- R3: A rising edge with `rst_n` high and `start` high has the same effect as reset: `done` low and `y` equal to the highest-power coefficient.
- R4: `done` stays low for the first NCOEF-2 edges after a reload and rises on edge NCOEF-1, which is edge 3 by default.
- R5: Once `done` is high and no reload occurs, `done` stays high and `y` stays constant, even if `x` changes.
- R6: A `start` pulse during an evaluation discards the partial result. The restarted evaluation gives the correct value for the new `x` with the timing of R4.
- R7: Every step keeps only the low WIDTH bits of the 2*WIDTH-bit product plus coefficient, so a result that overflows equals the exact polynomial value modulo 2^WIDTH, read as two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; reloads the evaluator |
| start | input | 1 | One-cycle pulse that reloads and begins a new evaluation |
| x | input | WIDTH | Signed evaluation point, held steady until `done` |
| y | output | WIDTH | Signed running result; final once `done` is high |
| done | output | 1 | High when `y` holds the final value |

## Verification
The assertions assume that `start` and `rst_n` are the only ways a new evaluation begins, and that `x` does not change during an evaluation. The hold checks therefore only apply after `done` and before the next reload. The stimulus changes `x` in the same cycle as a reload, or after `done` has risen. The only deliberate exception is the restart test, which changes `x` together with a new `start` pulse. The sweep covers every `x` from -64 to 63. It also covers the listed points 4, 7, 15 and -9, and wide values that overflow, with the expected results computed directly from the expanded polynomial in WIDTH-bit arithmetic.

// File: rtl/horner_pkg.sv
// Package: shared helpers for the Horner evaluator.
// Assumes coefficient counts of at least two.
package horner_pkg;

    // Width of a down-counter that must hold values 0 .. n-2.
    function automatic int idx_bits(input int n);
        if (n > 2)
            return $clog2(n - 1);
        else
            return 1;
    endfunction

endpackage

// File: rtl/horner_coef_sel.sv
// Module: coefficient selector.
// Returns the coefficient at a given power index and, separately, the
// highest-power coefficient. Assumes idx_i never exceeds NCOEF-2.
module horner_coef_sel
    import horner_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NCOEF = 4,
    parameter logic [NCOEF-1:0][WIDTH-1:0] COEFS = {32'sd3, -32'sd2, -32'sd4, 32'sd5}
) (
    input  logic [idx_bits(NCOEF)-1:0] idx_i,
    output logic signed [WIDTH-1:0]    coef_o,
    output logic signed [WIDTH-1:0]    top_o
);

    logic signed [WIDTH-1:0] table_q [NCOEF];

    // Unpack the parameter into one entry per power.
    for (genvar k = 0; k < NCOEF; k++) begin : g_tab
        assign table_q[k] = COEFS[k];
    end

    // Select the entry for the current step.
    always_comb begin
        coef_o = table_q[idx_i];
    end

    assign top_o = table_q[NCOEF-1];

endmodule

// File: rtl/horner_mac.sv
// Module: one Horner step, acc*x + c.
// The product is formed at 2*WIDTH bits and cut back to the low WIDTH
// bits before the add; the sum wraps at WIDTH bits. No overflow report.
module horner_mac #(
    parameter int WIDTH = 32
) (
    input  logic signed [WIDTH-1:0] acc_i,
    input  logic signed [WIDTH-1:0] x_i,
    input  logic signed [WIDTH-1:0] c_i,
    output logic signed [WIDTH-1:0] res_o
);

    localparam int PW = 2 * WIDTH;

    logic signed [PW-1:0] prod;

    // Full-width signed product, then wrapped add.
    always_comb begin
        prod  = PW'(acc_i) * PW'(x_i);
        res_o = prod[WIDTH-1:0] + c_i;
    end

endmodule

// File: rtl/horner_ctrl.sv
// Module: step sequencer.
// Counts the coefficient index down from NCOEF-2 to 0 after a reload
// (sync active-low reset or start pulse) and raises done on the edge
// that applies the index-0 step. Assumes NCOEF >= 2.
module horner_ctrl
    import horner_pkg::*;
#(
    parameter int NCOEF = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic                       reload_o,
    output logic                       step_o,
    output logic [idx_bits(NCOEF)-1:0] idx_o,
    output logic                       done_o
);

    localparam int CW = idx_bits(NCOEF);
    localparam logic [CW-1:0] FIRST_IDX = CW'(NCOEF - 2);

    logic [CW-1:0] cnt;
    logic          done_q;

    assign reload_o = !rst_n || start;
    assign step_o   = !reload_o && !done_q;
    assign idx_o    = cnt;
    assign done_o   = done_q;

    // Index counter and completion flag.
    always_ff @(posedge clk) begin
        if (reload_o) begin
            cnt    <= FIRST_IDX;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt == '0)
                done_q <= 1'b1;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(cnt) == '0 && !$past(start)));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (cnt <= FIRST_IDX));

endmodule

// File: rtl/horner_eval.sv
// Module: sequential Horner polynomial evaluator (top).
// Holds the running value in one register. A reload loads the
// highest-power coefficient; each following edge applies acc*x + c[idx]
// until done. Assumes x is held steady from reload until done.
module horner_eval
    import horner_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NCOEF = 4,
    parameter logic [NCOEF-1:0][WIDTH-1:0] COEFS = {32'sd3, -32'sd2, -32'sd4, 32'sd5}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [WIDTH-1:0] x,
    output logic signed [WIDTH-1:0] y,
    output logic                    done
);

    localparam int CW = idx_bits(NCOEF);

    logic                    reload;
    logic                    step;
    logic [CW-1:0]           idx;
    logic signed [WIDTH-1:0] coef;
    logic signed [WIDTH-1:0] top_coef;
    logic signed [WIDTH-1:0] next_acc;
    logic signed [WIDTH-1:0] acc;

    horner_ctrl #(.NCOEF(NCOEF)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .reload_o (reload),
        .step_o   (step),
        .idx_o    (idx),
        .done_o   (done)
    );

    horner_coef_sel #(.WIDTH(WIDTH), .NCOEF(NCOEF), .COEFS(COEFS)) u_coef (
        .idx_i  (idx),
        .coef_o (coef),
        .top_o  (top_coef)
    );

    horner_mac #(.WIDTH(WIDTH)) u_mac (
        .acc_i (acc),
        .x_i   (x),
        .c_i   (coef),
        .res_o (next_acc)
    );

    // Running value: load on reload, advance on each step, else hold.
    always_ff @(posedge clk) begin
        if (reload)
            acc <= top_coef;
        else if (step)
            acc <= next_acc;
    end

    assign y = acc;

    // R2
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && y == top_coef));

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && y == top_coef));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R5
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(y));

endmodule

// File: tb/sim_horner_eval.sv
module sim_horner_eval;

    localparam int W = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic signed [W-1:0] x = '0;
    logic signed [W-1:0] y;
    logic                done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    horner_eval u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .x     (x),
        .y     (y),
        .done  (done)
    );

    function automatic logic signed [W-1:0] poly(input logic signed [W-1:0] v);
        logic signed [W-1:0] v2, v3;
        v2 = v * v;
        v3 = v2 * v;
        return 3 * v3 - 2 * v2 - 4 * v + 5;
    endfunction

    task automatic chk(input string req, input logic signed [W-1:0] act,
                       input logic signed [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reload via reset or start, then walk through the three steps.
    task automatic eval(input logic signed [W-1:0] xv, input bit via_reset,
                        input string req);
        @(negedge clk);
        x = xv;
        if (via_reset) rst_n = 1'b0; else start = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        start = 1'b0;
        chk(via_reset ? "R2" : "R3", y, 3);
        chk(via_reset ? "R2" : "R3", W'(done), 0);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R4", W'(done), (k == 3) ? 1 : 0);
        end
        chk(req, y, poly(xv));
    endtask

    initial begin
        logic signed [W-1:0] held;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2", W'(done), 0);
        chk("R2", y, 3);

        // R1 listed points
        eval(4, 1'b1, "R1");
        eval(7, 1'b1, "R1");
        eval(15, 1'b0, "R1");
        eval(-9, 1'b0, "R1");

        // R1 sweep of small values
        for (int v = -64; v < 64; v++) eval(W'(v), 1'b0, "R1");

        // R7 overflowing inputs
        eval(32'sh7fffffff, 1'b0, "R7");
        eval(32'sh80000000, 1'b0, "R7");
        eval(32'sh12345678, 1'b1, "R7");
        eval(-32'sd100000, 1'b0, "R7");

        // R5 hold after done while x changes
        held = y;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            x = x + 32'sd1234567;
            @(negedge clk);
            chk("R5", y, held);
            chk("R5", W'(done), 1);
        end

        // R6 restart mid-run
        @(negedge clk);
        x = 11;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        eval(-21, 1'b0, "R6");

        // R2 reset mid-run then a fresh evaluation
        @(negedge clk);
        x = 5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2", W'(done), 0);
        chk("R2", y, 3);
        eval(33, 1'b0, "R6");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule